// File: doc/BRIEF.md
# SCSI Initiator Block-Move Sequencer

This block carries out one block-move instruction on behalf of a SCSI initiator. A decoder hands it an opcode bit, the bus phase it expects, a byte count and a start address, then pulses `start`. The block first confirms that it holds the initiator role and that the count is non-zero. It then waits for each REQ from the target that it has not yet answered. On each REQ it compares the phase latched at the rising edge of REQ with the expected phase. It moves one wide bus word per REQ/ACK handshake. On the memory side it reads or writes one byte per cycle.

A chained move that receives data and ends partway through a wide word keeps the unused upper byte. The next chained receive writes that byte first, so the split word is completed across the two moves. A plain move drops that byte instead. ATN or a parity error during the move ends it with a halt interrupt. A control input chooses whether the halt takes effect at the next handshake boundary or only after the last byte. Each instruction ends with a one-cycle `irq` pulse. The code that comes with the pulse is 0 for done, 1 for phase mismatch, 2 for illegal count, 3 for halt and 4 for the role error.

Top module: `scsi_bmov_seq`

## Requirements
- R1: A start with a byte count of zero ends with `irq_code` 2. No ACK and no memory write take place.
- R2: A start while `role_init` is low ends with `irq_code` 4 and no ACK or memory write. This holds even when the count is non-zero and REQ is pending.
- R3: ACK rises only in answer to a REQ that is high while ACK is low. No ACK and no memory access occur while REQ stays low. ACK falls only after REQ has been seen low, and ACK is high only while `busy` is high.
- R4: The phase lines are latched when REQ rises and are compared with `instr_phase`. If they differ, the move ends with `irq_code` 2'd1. That REQ gets no ACK and nothing is written.
- R5: A receive move is one where `instr_phase` bit 0 is 1. For each word it writes bits 7:0 to the current address and then bits 15:8 to the next address. The address increments and the count decrements on each byte. The move ends with `irq_code` 0 when the count reaches zero, and `busy` is low in the cycle after `irq`.
- R6: A send move is one where `instr_phase` bit 0 is 0. It reads bytes from consecutive addresses and places the first byte of each word in bits 7:0 of `scsi_tx_data`. The data stays stable while ACK is high. On an odd final byte, bits 15:8 are driven as 0.
- R7: A chained receive (`instr_opc` = 0) that ends on an odd byte keeps bits 15:8 of its last word. The next chained receive writes that byte to its own start address before any bus transfer, and it counts as one byte of that move.
- R8: A plain receive (`instr_opc` = 1) that ends on an odd byte discards bits 15:8 of its last word. A plain move also discards any byte still kept from a chained move, so the next chained receive starts with data from the bus.
- R9: With `halt_now` = 1, ATN or a parity error seen while busy lets the current handshake finish. No further REQ is then acknowledged, and the move ends with `irq_code` 3.
- R10: With `halt_now` = 0, ATN or a parity error seen while busy lets the move transfer all of its bytes. It then ends with `irq_code` 3 instead of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to execute the presented instruction |
| instr_opc | input | 1 | 0 = chained move, 1 = plain move |
| instr_phase | input | PH_W | Expected bus phase; bit 0 set means receive |
| instr_count | input | CNT_W | Number of bytes to move |
| instr_addr | input | ADDR_W | Memory start address |
| role_init | input | 1 | High when connected to the bus as initiator |
| halt_now | input | 1 | 1 = halt at next handshake boundary, 0 = halt after the move |
| scsi_req | input | 1 | REQ from the target |
| scsi_atn | input | 1 | ATN line |
| scsi_perr | input | 1 | Parity error seen on received data |
| scsi_phase | input | PH_W | Bus phase lines |
| scsi_rx_data | input | LANES*8 | Bus data from the target |
| scsi_ack | output | 1 | ACK to the target |
| scsi_tx_data | output | LANES*8 | Bus data to the target |
| mem_we | output | 1 | Memory byte write strobe |
| mem_re | output | 1 | Memory byte read strobe; data returns in the same cycle |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data |
| busy | output | 1 | An instruction is in progress |
| irq | output | 1 | One-cycle end-of-instruction pulse |
| irq_code | output | 3 | Reason code qualified by `irq` |

## Verification
The hardest state to reach is a kept byte that is still pending when the next instruction starts. It exists only after a chained receive with an odd count. It shows up only as the first write of a later chained receive, and any plain move in between must erase it. The bench runs chained moves of three and then two bytes back to back, so the same byte lane is kept twice. It then issues a plain move and a chained move with a known bus byte stream, and checks which byte lands at each start address. The halt cases are timed by raising ATN or parity while ACK is high on the first word. This places the halt request exactly between two handshakes.

// File: rtl/bmov_pkg.sv
package bmov_pkg;

   typedef enum logic [2:0] {
      IRQ_DONE     = 3'd0,
      IRQ_MISMATCH = 3'd1,
      IRQ_ILLEGAL  = 3'd2,
      IRQ_HALT     = 3'd3,
      IRQ_ROLE     = 3'd4
   } irq_code_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CHECK,
      ST_RES,
      ST_WAIT,
      ST_CMP,
      ST_XFER,
      ST_ACK,
      ST_END
   } seq_st_e;

   localparam logic OPC_CHAIN = 1'b0;

endpackage

// File: rtl/bmov_phase_latch.sv
module bmov_phase_latch #(
   parameter int PH_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req,
   input  logic [PH_W-1:0] phase,
   output logic [PH_W-1:0] lat_phase
);

   logic req_d;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_d     <= 1'b0;
         lat_phase <= '0;
      end else begin
         req_d <= req;
         if (req && !req_d) lat_phase <= phase;
      end
   end

endmodule

// File: rtl/bmov_residual.sv
module bmov_residual (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  logic [7:0] din,
   input  logic       take,
   input  logic       clear,
   output logic       valid,
   output logic [7:0] dout
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid <= 1'b0;
         dout  <= '0;
      end else if (load) begin
         valid <= 1'b1;
         dout  <= din;
      end else if (take || clear) begin
         valid <= 1'b0;
      end
   end

endmodule

// File: rtl/scsi_bmov_seq.sv
module scsi_bmov_seq
   import bmov_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 16,
   parameter int LANES  = 2,
   parameter int PH_W   = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic                 instr_opc,
   input  logic [PH_W-1:0]      instr_phase,
   input  logic [CNT_W-1:0]     instr_count,
   input  logic [ADDR_W-1:0]    instr_addr,
   input  logic                 role_init,
   input  logic                 halt_now,
   input  logic                 scsi_req,
   input  logic                 scsi_atn,
   input  logic                 scsi_perr,
   input  logic [PH_W-1:0]      scsi_phase,
   input  logic [LANES*8-1:0]   scsi_rx_data,
   output logic                 scsi_ack,
   output logic [LANES*8-1:0]   scsi_tx_data,
   output logic                 mem_we,
   output logic                 mem_re,
   output logic [ADDR_W-1:0]    mem_addr,
   output logic [7:0]           mem_wdata,
   input  logic [7:0]           mem_rdata,
   output logic                 busy,
   output logic                 irq,
   output logic [2:0]           irq_code
);

   localparam int DW   = LANES * 8;
   localparam int LI_W = (LANES > 1) ? $clog2(LANES) : 1;
   localparam logic [LI_W-1:0]  LI_LAST = LI_W'(LANES - 1);
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   if (LANES < 1 || LANES > 2) begin : g_bad_lanes
      $error("scsi_bmov_seq: LANES must be 1 or 2");
   end
   if (CNT_W < 2 || ADDR_W < 2 || PH_W < 1) begin : g_bad_width
      $error("scsi_bmov_seq: width parameter too small");
   end

   seq_st_e                   st_q;
   irq_code_e                 code_q;
   logic                      chain_q;
   logic [PH_W-1:0]           exp_q;
   logic [CNT_W-1:0]          cnt_q;
   logic [ADDR_W-1:0]         addr_q;
   logic [LANES-1:0][7:0]     buf_q;
   logic [LI_W-1:0]           li_q;
   logic                      halt_q;
   logic                      ack_q;
   logic [PH_W-1:0]           lat_phase;
   logic                      rx;
   logic                      res_load, res_take, res_clear, res_valid;
   logic [7:0]                res_byte;
   irq_code_e                 end_code;

   bmov_phase_latch #(.PH_W(PH_W)) u_phase (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (scsi_req),
      .phase     (scsi_phase),
      .lat_phase (lat_phase)
   );

   assign rx        = exp_q[0];
   assign res_load  = (st_q == ST_XFER) && rx && (chain_q == 1'b1 ? 1'b0 : 1'b1) == 1'b0
                      && (cnt_q == CNT_ONE) && (li_q != LI_LAST);
   assign res_take  = (st_q == ST_RES);
   assign res_clear = (st_q == ST_CHECK) && !chain_q;

   if (LANES > 1) begin : g_res
      bmov_residual u_res (
         .clk   (clk),
         .rst_n (rst_n),
         .load  (res_load),
         .din   (buf_q[LANES-1]),
         .take  (res_take),
         .clear (res_clear),
         .valid (res_valid),
         .dout  (res_byte)
      );
   end else begin : g_nores
      assign res_valid = 1'b0;
      assign res_byte  = 8'h00;
   end

   assign end_code = halt_q ? IRQ_HALT : IRQ_DONE;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         code_q  <= IRQ_DONE;
         chain_q <= 1'b0;
         exp_q   <= '0;
         cnt_q   <= '0;
         addr_q  <= '0;
         buf_q   <= '0;
         li_q    <= '0;
         halt_q  <= 1'b0;
         ack_q   <= 1'b0;
      end else begin
         if (st_q != ST_IDLE && (scsi_atn || scsi_perr)) halt_q <= 1'b1;
         case (st_q)
            ST_IDLE: if (start) begin
               chain_q <= (instr_opc == OPC_CHAIN);
               exp_q   <= instr_phase;
               cnt_q   <= instr_count;
               addr_q  <= instr_addr;
               halt_q  <= 1'b0;
               st_q    <= ST_CHECK;
            end
            ST_CHECK: begin
               if (!role_init) begin
                  code_q <= IRQ_ROLE;
                  st_q   <= ST_END;
               end else if (cnt_q == '0) begin
                  code_q <= IRQ_ILLEGAL;
                  st_q   <= ST_END;
               end else if (chain_q && rx && res_valid) begin
                  st_q <= ST_RES;
               end else begin
                  st_q <= ST_WAIT;
               end
            end
            ST_RES: begin
               addr_q <= addr_q + 1'b1;
               cnt_q  <= cnt_q - 1'b1;
               if (cnt_q == CNT_ONE) begin
                  code_q <= end_code;
                  st_q   <= ST_END;
               end else begin
                  st_q <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (halt_q && halt_now) begin
                  code_q <= IRQ_HALT;
                  st_q   <= ST_END;
               end else if (scsi_req && !ack_q) begin
                  st_q <= ST_CMP;
               end
            end
            ST_CMP: begin
               if (lat_phase != exp_q) begin
                  code_q <= IRQ_MISMATCH;
                  st_q   <= ST_END;
               end else begin
                  buf_q <= rx ? scsi_rx_data : '0;
                  li_q  <= '0;
                  st_q  <= ST_XFER;
               end
            end
            ST_XFER: begin
               if (!rx) buf_q[li_q] <= mem_rdata;
               addr_q <= addr_q + 1'b1;
               cnt_q  <= cnt_q - 1'b1;
               if (cnt_q == CNT_ONE || li_q == LI_LAST) begin
                  ack_q <= 1'b1;
                  st_q  <= ST_ACK;
               end else begin
                  li_q <= li_q + 1'b1;
               end
            end
            ST_ACK: if (!scsi_req) begin
               ack_q <= 1'b0;
               if (cnt_q == '0) begin
                  code_q <= end_code;
                  st_q   <= ST_END;
               end else begin
                  st_q <= ST_WAIT;
               end
            end
            ST_END:  st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign scsi_ack     = ack_q;
   assign scsi_tx_data = DW'(buf_q);
   assign mem_we       = ((st_q == ST_XFER) && rx) || (st_q == ST_RES);
   assign mem_re       = (st_q == ST_XFER) && !rx;
   assign mem_addr     = addr_q;
   assign mem_wdata    = (st_q == ST_RES) ? res_byte : buf_q[li_q];
   assign busy         = (st_q != ST_IDLE);
   assign irq          = (st_q == ST_END);
   assign irq_code     = code_q;

endmodule

// File: rtl/bmov_checks.sv
module bmov_checks #(
   parameter int DW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          scsi_req,
   input logic          scsi_ack,
   input logic [DW-1:0] scsi_tx_data,
   input logic          mem_we,
   input logic          mem_re,
   input logic          busy,
   input logic          irq
);

   // R3: ACK may only drop once REQ has been seen low
   p_ack_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(scsi_ack) |-> !$past(scsi_req));

   // R3: ACK only while an instruction runs
   p_ack_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      scsi_ack |-> busy);

   // R6: driven word holds during the whole ACK pulse
   p_tx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (scsi_ack && $past(scsi_ack)) |-> $stable(scsi_tx_data));

   // R5: memory strobes only while busy and never both at once
   p_mem_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we || mem_re) |-> (busy && !(mem_we && mem_re)));

   // R5: busy drops right after the end pulse
   p_irq_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !busy);

   // R4: an instruction never ends with a handshake left open
   p_irq_noack_r4: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> !scsi_ack);

endmodule

bind scsi_bmov_seq bmov_checks #(.DW(DW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .scsi_req     (scsi_req),
   .scsi_ack     (scsi_ack),
   .scsi_tx_data (scsi_tx_data),
   .mem_we       (mem_we),
   .mem_re       (mem_re),
   .busy         (busy),
   .irq          (irq)
);

// File: tb/scsi_bmov_seq_tb_top.sv
`timescale 1ns/1ps
module scsi_bmov_seq_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        instr_opc = 1'b1;
   logic [2:0]  instr_phase = 3'b000;
   logic [15:0] instr_count = '0;
   logic [15:0] instr_addr = '0;
   logic        role_init = 1'b1;
   logic        halt_now = 1'b0;
   logic        scsi_req = 1'b0;
   logic        scsi_atn = 1'b0;
   logic        scsi_perr = 1'b0;
   logic [2:0]  scsi_phase = 3'b000;
   logic [15:0] scsi_rx_data = '0;
   logic        scsi_ack;
   logic [15:0] scsi_tx_data;
   logic        mem_we, mem_re;
   logic [15:0] mem_addr;
   logic [7:0]  mem_wdata, mem_rdata;
   logic        busy, irq;
   logic [2:0]  irq_code;

   always #2 clk = ~clk;

   scsi_bmov_seq dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .instr_opc(instr_opc),
      .instr_phase(instr_phase), .instr_count(instr_count), .instr_addr(instr_addr),
      .role_init(role_init), .halt_now(halt_now), .scsi_req(scsi_req),
      .scsi_atn(scsi_atn), .scsi_perr(scsi_perr), .scsi_phase(scsi_phase),
      .scsi_rx_data(scsi_rx_data), .scsi_ack(scsi_ack), .scsi_tx_data(scsi_tx_data),
      .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .busy(busy), .irq(irq), .irq_code(irq_code)
   );

   logic [7:0] bmem [256];
   logic [7:0] txq [64];
   int         ntx;
   int         nwr = 0, nack = 0, nirq = 0;
   int         last_code = 0;
   logic       ack_q = 1'b0;
   logic [7:0] rx_seq = 8'h10;
   int         nchk = 0, nerr = 0;
   int         atn_at = -1;
   logic       use_perr = 1'b0;

   assign mem_rdata = bmem[mem_addr[7:0]];

   always @(posedge clk) begin
      if (mem_we) begin
         bmem[mem_addr[7:0]] <= mem_wdata;
         nwr <= nwr + 1;
      end
      ack_q <= scsi_ack;
      if (scsi_ack && !ack_q) nack <= nack + 1;
   end

   always @(negedge clk) begin
      if (irq) begin
         nirq      <= nirq + 1;
         last_code <= int'(irq_code);
      end
   end

   task automatic chk(string tag, int act, int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // target side of one word: returns 1 if acknowledged
   task automatic hs(input logic [2:0] ph, input int w, input int snap, output bit acked);
      @(negedge clk);
      scsi_phase   = ph;
      scsi_rx_data = {rx_seq + 8'd1, rx_seq};
      scsi_req     = 1'b1;
      while (!scsi_ack && nirq == snap) @(negedge clk);
      acked = scsi_ack;
      if (acked) begin
         txq[ntx]   = scsi_tx_data[7:0];
         txq[ntx+1] = scsi_tx_data[15:8];
         ntx += 2;
         rx_seq += 8'd2;
         if (w == atn_at) begin
            if (use_perr) scsi_perr = 1'b1;
            else scsi_atn = 1'b1;
         end
         @(negedge clk);
         scsi_req = 1'b0;
         while (scsi_ack) @(negedge clk);
      end
   endtask

   task automatic run_move(input logic opc, input logic [2:0] eph, input logic [2:0] tph,
                           input int cnt, input int addr, input int nwords,
                           output int code, output int acks, output int wrs);
      int  snap, a0, w0;
      bit  ok;
      ntx = 0;
      @(negedge clk);
      instr_opc   = opc;
      instr_phase = eph;
      instr_count = 16'(cnt);
      instr_addr  = 16'(addr);
      snap = nirq; a0 = nack; w0 = nwr;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int w = 0; w < nwords; w++) begin
         if (nirq == snap) begin
            hs(tph, w, snap, ok);
         end
      end
      while (nirq == snap) @(negedge clk);
      scsi_req  = 1'b0;
      scsi_atn  = 1'b0;
      scsi_perr = 1'b0;
      @(negedge clk);
      code = last_code; acks = nack - a0; wrs = nwr - w0;
   endtask

   // {opc, phase, count, addr, expected code}
   localparam logic [22:0] VEC [6] = '{
      {1'b1, 3'b001, 8'd4, 8'h10, 3'd0},
      {1'b1, 3'b000, 8'd4, 8'h20, 3'd0},
      {1'b1, 3'b000, 8'd3, 8'h28, 3'd0},
      {1'b1, 3'b001, 8'd5, 8'h30, 3'd0},
      {1'b1, 3'b001, 8'd0, 8'h00, 3'd2},
      {1'b1, 3'b000, 8'd1, 8'h2E, 3'd0}
   };

   initial begin
      repeat (150000) @(posedge clk);
      nerr++;
      $display("FAIL R3 watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end

   initial begin
      int code, acks, wrs, cnt, addr, base;
      for (int i = 0; i < 256; i++) bmem[i] = 8'(i) ^ 8'hA5;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R3 reset ack", int'(scsi_ack), 0);
      chk("R5 reset busy", int'(busy), 0);
      chk("R5 reset irq", int'(irq), 0);
      chk("R5 reset mem_we", int'(mem_we), 0);

      for (int i = 0; i < 6; i++) begin
         logic [22:0] v;
         v    = VEC[i];
         cnt  = int'(v[18:11]);
         addr = int'(v[10:3]);
         base = int'(rx_seq);
         run_move(v[22], v[21:19], v[21:19], cnt, addr, (cnt + 1) / 2, code, acks, wrs);
         chk(v[2:0] == 3'd2 ? "R1 code" : "R5 code", code, int'(v[2:0]));
         chk("R5 ack count", acks, (cnt + 1) / 2);
         if (v[19]) begin
            chk("R5 write count", wrs, cnt);
            for (int k = 0; k < cnt; k++)
               chk("R5 rx byte", int'(bmem[(addr + k) & 255]), (base + k) & 255);
         end else begin
            chk("R6 no write", wrs, 0);
            for (int k = 0; k < cnt; k++)
               chk("R6 tx byte", int'(txq[k]), int'(8'(addr + k) ^ 8'hA5));
            if (cnt % 2 == 1) chk("R6 pad lane", int'(txq[cnt]), 0);
         end
      end

      // R2: not initiator
      role_init = 1'b0;
      run_move(1'b1, 3'b001, 3'b001, 4, 8'h90, 1, code, acks, wrs);
      chk("R2 code", code, 4);
      chk("R2 acks", acks, 0);
      chk("R2 writes", wrs, 0);
      role_init = 1'b1;

      // R4: phase mismatch
      run_move(1'b1, 3'b001, 3'b011, 4, 8'h94, 1, code, acks, wrs);
      chk("R4 code", code, 1);
      chk("R4 acks", acks, 0);
      chk("R4 writes", wrs, 0);

      // R3: no REQ means no activity
      begin
         int w0, a0;
         w0 = nwr; a0 = nack;
         @(negedge clk);
         instr_opc = 1'b1; instr_phase = 3'b001; instr_count = 16'd2; instr_addr = 16'hA0;
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         repeat (12) @(negedge clk);
         chk("R3 waits busy", int'(busy), 1);
         chk("R3 waits ack", nack - a0, 0);
         chk("R3 waits mem", nwr - w0, 0);
         base = int'(rx_seq);
         scsi_phase = 3'b001; scsi_rx_data = {rx_seq + 8'd1, rx_seq}; scsi_req = 1'b1;
         while (!scsi_ack) @(negedge clk);
         rx_seq += 8'd2;
         repeat (4) @(negedge clk);
         chk("R3 ack held with req", int'(scsi_ack), 1);
         scsi_req = 1'b0;
         while (busy) @(negedge clk);
         chk("R3 done code", last_code, 0);
         chk("R5 late req byte", int'(bmem[8'hA1]), (base + 1) & 255);
      end

      // R7: chained odd receive carries the upper byte
      base = int'(rx_seq);
      run_move(1'b0, 3'b001, 3'b001, 3, 8'h40, 2, code, acks, wrs);
      chk("R7 first code", code, 0);
      chk("R7 first writes", wrs, 3);
      chk("R7 first last byte", int'(bmem[8'h42]), (base + 2) & 255);
      chk("R7 first untouched", int'(bmem[8'h43]), int'(8'h43 ^ 8'hA5));
      run_move(1'b0, 3'b001, 3'b001, 2, 8'h50, 1, code, acks, wrs);
      chk("R7 carried byte", int'(bmem[8'h50]), (base + 3) & 255);
      chk("R7 next byte", int'(bmem[8'h51]), (base + 4) & 255);
      chk("R7 second acks", acks, 1);
      chk("R7 second writes", wrs, 2);

      // R8: plain move discards the kept byte
      run_move(1'b1, 3'b001, 3'b001, 2, 8'h58, 1, code, acks, wrs);
      chk("R8 plain discards kept", int'(bmem[8'h58]), (base + 6) & 255);
      chk("R8 plain writes", wrs, 2);

      // R8: plain odd end keeps nothing
      base = int'(rx_seq);
      run_move(1'b1, 3'b001, 3'b001, 1, 8'h5C, 1, code, acks, wrs);
      chk("R8 plain odd writes", wrs, 1);
      run_move(1'b0, 3'b001, 3'b001, 2, 8'h5E, 1, code, acks, wrs);
      chk("R8 chained after plain", int'(bmem[8'h5E]), (base + 2) & 255);
      chk("R8 chained after plain hi", int'(bmem[8'h5F]), (base + 3) & 255);

      // R9: immediate halt on ATN
      halt_now = 1'b1; atn_at = 0; use_perr = 1'b0;
      base = int'(rx_seq);
      run_move(1'b1, 3'b001, 3'b001, 6, 8'h80, 3, code, acks, wrs);
      chk("R9 code", code, 3);
      chk("R9 acks", acks, 1);
      chk("R9 writes", wrs, 2);
      chk("R9 third byte untouched", int'(bmem[8'h82]), int'(8'h82 ^ 8'hA5));

      // R10: deferred halt on parity error
      halt_now = 1'b0; atn_at = 0; use_perr = 1'b1;
      base = int'(rx_seq);
      run_move(1'b1, 3'b001, 3'b001, 6, 8'hC0, 3, code, acks, wrs);
      chk("R10 code", code, 3);
      chk("R10 acks", acks, 3);
      chk("R10 writes", wrs, 6);
      chk("R10 last byte", int'(bmem[8'hC5]), (base + 5) & 255);
      atn_at = -1;

      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end

endmodule